// File: doc/BRIEF.md
# Clock Generation Slice with Glitch-Free Source Selection

This block produces one derived clock from a set of free-running source clocks. A handshaked glitch-free selector chooses between a base clock (index 0) and the output of a simple auxiliary selector (index 1). The auxiliary selector picks one of several side clocks. It may glitch when its pick changes, so software moves the main selector to the base clock first. A two-bit one-hot status, `src_active`, shows which main input currently owns the internal clock, so software can confirm that a switch has finished before it touches the divider.

The internal clock then passes through a combined enable gate and divider. The divider word has an integer part in bits [DW-1:8] and an 8-bit fraction in bits [7:0]. An integer part of 1 passes the clock through unchanged. Larger integers divide. A phase accumulator stretches some periods by one source cycle so that the average period includes the fraction. The enable and the divider are controlled by a state machine in the internal clock domain. Its states are OFF (output low), PASS (gated pass-through), HIGH and LOW (the two halves of a divided period). Its transitions are: OFF->PASS when the enable is on and the integer is 1; OFF->HIGH when the enable is on and the integer is at least 2; PASS->OFF when the enable drops or the integer is no longer 1; HIGH->LOW when the high count expires; LOW->HIGH when the low count expires with the enable on and the integer at least 2; LOW->OFF when the low count expires otherwise.

Top module: `clkslice`

## Requirements
- R1: While reset is held, `src_active` is 00 and `clk_out` is low. After reset is released with `main_pick`=0, `src_active` reads 01 (bit 0 = base clock, bit 1 = auxiliary path) within 5 base clock cycles.
- R2: `src_active` never has both bits set. During a switch, the old bit clears before the new bit sets.
- R3: After `main_pick` changes and is held, the matching `src_active` bit sets within 100 ns. From then on, `clk_out` follows the newly picked source.
- R4: `side_pick` selects `side_clks[side_pick]` as the auxiliary path. With `main_pick`=1, the output is derived from that clock.
- R5: An integer part of 1 passes the picked clock through with the same period and high time, whatever the fraction is.
- R6: With an integer part N>=2 and a zero fraction, the output period is N source cycles, and the output is high for floor(N/2) of them.
- R7: With integer N>=2 and fraction F, any 256 consecutive output periods span exactly 256*N+F source cycles. Each period is N or N+1 cycles long.
- R8: When `slice_en` is low, the output finishes its current period (divided) or its current low phase (pass-through) and then stays low. No high pulse is ever shorter than the configured high time.
- R9: An integer part of 0 holds the output low. Writing a non-zero integer afterwards restarts the output.
- R10: When `slice_en` is raised again, the first high pulse and the first period have their full configured lengths.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset |
| base_clk | input | 1 | Free-running base clock, main index 0 |
| side_clks | input | AUX_N | Free-running side clocks feeding the auxiliary selector |
| side_pick | input | $clog2(AUX_N) | Auxiliary selector choice |
| main_pick | input | 1 | Glitch-free selector choice: 0 base, 1 auxiliary path |
| slice_en | input | 1 | Output enable |
| div_cfg | input | INT_W+8 | Integer part in the upper bits, 8-bit fraction in the lower bits |
| clk_out | output | 1 | Generated clock |
| src_active | output | 2 | One-hot owner of the internal clock |

## Verification
A stuck or mis-sequenced selector enable shows up at `src_active` within a few source cycles: both bits set at once, or a bit that never sets. The output then either stops or runs at the wrong period. A wrong divider count or a wrong fraction accumulator changes the measured period or high time on the very next output period. Across 256 periods it changes the summed duration, so even a single missed carry is visible. A wrong enable synchroniser or gate shows up as edges that keep arriving after the enable drops, or as a short first or last high pulse.

// File: rtl/clkslice_pkg.sv
`timescale 1ns/1ps
package clkslice_pkg;
    localparam int FRAC_BITS = 8;

    typedef enum logic [1:0] {
        DS_OFF  = 2'd0,
        DS_PASS = 2'd1,
        DS_HIGH = 2'd2,
        DS_LOW  = 2'd3
    } div_state_t;
endpackage

// File: rtl/clkslice_aux_sel.sv
`timescale 1ns/1ps
module clkslice_aux_sel #(
    parameter int N = 4,
    localparam int SW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  clks,
    input  logic [SW-1:0] pick,
    output logic          aux_clk
);
    // Plain selector: output may glitch when pick changes.
    always_comb begin
        aux_clk = 1'b0;
        for (int k = 0; k < N; k++) begin
            if (pick == SW'(k)) aux_clk = clks[k];
        end
    end
endmodule

// File: rtl/clkslice_gf_mux.sv
`timescale 1ns/1ps
module clkslice_gf_mux #(
    parameter int NSRC = 2,
    localparam int SW = (NSRC > 1) ? $clog2(NSRC) : 1
) (
    input  logic            rst_n,
    input  logic [NSRC-1:0] src_clk,
    input  logic [SW-1:0]   pick,
    output logic            mclk,
    output logic [NSRC-1:0] own_q
);
    logic [NSRC-1:0] gated;

    for (genvar i = 0; i < NSRC; i++) begin : g_leg
        logic req;
        logic sync1, sync2;
        logic en_q;

        // Ask for ownership only when picked and every other leg has let go.
        assign req = (pick == SW'(i)) &&
                     ((own_q & ~(NSRC'(1) << i)) == '0);

        always_ff @(posedge src_clk[i] or negedge rst_n) begin
            if (!rst_n) begin
                sync1 <= 1'b0;
                sync2 <= 1'b0;
            end else begin
                sync1 <= req;
                sync2 <= sync1;
            end
        end

        // Enable changes only while this source is low.
        always_ff @(negedge src_clk[i] or negedge rst_n) begin
            if (!rst_n) en_q <= 1'b0;
            else        en_q <= sync2;
        end

        assign own_q[i] = en_q;
        assign gated[i] = src_clk[i] & en_q;

        AST_SINGLE_OWNER: assert property (@(posedge src_clk[i]) disable iff (!rst_n)
            $onehot0(own_q)); // R2
    end

    assign mclk = |gated;
endmodule

// File: rtl/clkslice_divgate.sv
`timescale 1ns/1ps
module clkslice_divgate
    import clkslice_pkg::*;
#(
    parameter int INT_W  = 8,
    parameter int FRAC_W = FRAC_BITS,
    localparam int DW = INT_W + FRAC_W,
    localparam int CW = INT_W + 1
) (
    input  logic          rst_n,
    input  logic          mclk,
    input  logic          en_req,
    input  logic [DW-1:0] div_cfg,
    output logic          clk_out
);
    div_state_t state, nxt;

    logic              en_s1, en_s;
    logic [INT_W-1:0]  int_part;
    logic [FRAC_W-1:0] frac_part;
    logic [FRAC_W:0]   acc_sum;
    logic [FRAC_W-1:0] acc;
    logic [CW-1:0]     per, hi_len, lo_len, lo_q, cnt;
    logic              div_q, gate_q;
    logic              is_pass, is_div;

    assign int_part  = div_cfg[DW-1:FRAC_W];
    assign frac_part = div_cfg[FRAC_W-1:0];
    assign is_pass   = (int_part == INT_W'(1));
    assign is_div    = (int_part > INT_W'(1));

    // Period of the next output cycle, stretched on accumulator carry.
    assign acc_sum = {1'b0, acc} + {1'b0, frac_part};
    assign per     = {1'b0, int_part} + {{INT_W{1'b0}}, acc_sum[FRAC_W]};
    assign hi_len  = per >> 1;
    assign lo_len  = per - hi_len;

    // Enable resynchronised into the internal clock domain.
    always_ff @(posedge mclk or negedge rst_n) begin
        if (!rst_n) begin
            en_s1 <= 1'b0;
            en_s  <= 1'b0;
        end else begin
            en_s1 <= en_req;
            en_s  <= en_s1;
        end
    end

    always_comb begin
        nxt = state;
        unique case (state)
            DS_OFF: begin
                if (en_s && is_pass)     nxt = DS_PASS;
                else if (en_s && is_div) nxt = DS_HIGH;
            end
            DS_PASS: begin
                if (!en_s || !is_pass) nxt = DS_OFF;
            end
            DS_HIGH: begin
                if (cnt == '0) nxt = DS_LOW;
            end
            DS_LOW: begin
                if (cnt == '0) nxt = (en_s && is_div) ? DS_HIGH : DS_OFF;
            end
        endcase
    end

    // State register
    always_ff @(posedge mclk or negedge rst_n) begin
        if (!rst_n) state <= DS_OFF;
        else        state <= nxt;
    end

    // Outputs and datapath
    always_ff @(posedge mclk or negedge rst_n) begin
        if (!rst_n) begin
            cnt   <= '0;
            lo_q  <= '0;
            acc   <= '0;
            div_q <= 1'b0;
        end else begin
            div_q <= (nxt == DS_HIGH);
            if (nxt == DS_HIGH && state != DS_HIGH) begin
                cnt  <= hi_len - CW'(1);
                lo_q <= lo_len;
                acc  <= acc_sum[FRAC_W-1:0];
            end else if (nxt == DS_LOW && state == DS_HIGH) begin
                cnt <= lo_q - CW'(1);
            end else if (cnt != '0) begin
                cnt <= cnt - CW'(1);
            end
            if (nxt == DS_OFF) acc <= '0;
        end
    end

    // Pass-through gate updated while the internal clock is low.
    always_ff @(negedge mclk or negedge rst_n) begin
        if (!rst_n) gate_q <= 1'b0;
        else        gate_q <= (state == DS_PASS);
    end

    assign clk_out = (mclk & gate_q) | div_q;

    AST_START_NEEDS_EN: assert property (@(posedge mclk) disable iff (!rst_n)
        $rose(div_q) |-> $past(en_s)); // R8
    AST_OFF_QUIET: assert property (@(posedge mclk) disable iff (!rst_n)
        (state == DS_OFF) |-> (!div_q && !gate_q)); // R9
    AST_DIV_NO_GATE: assert property (@(posedge mclk) disable iff (!rst_n)
        (state == DS_HIGH) |-> !gate_q); // R5
    AST_LOW_HELD: assert property (@(posedge mclk) disable iff (!rst_n)
        (state == DS_LOW) |-> !div_q); // R6
endmodule

// File: rtl/clkslice.sv
`timescale 1ns/1ps
module clkslice
    import clkslice_pkg::*;
#(
    parameter int AUX_N  = 4,
    parameter int INT_W  = 8,
    parameter int FRAC_W = FRAC_BITS,
    localparam int AUX_SW = (AUX_N > 1) ? $clog2(AUX_N) : 1,
    localparam int DW     = INT_W + FRAC_W
) (
    input  logic              rst_n,
    input  logic              base_clk,
    input  logic [AUX_N-1:0]  side_clks,
    input  logic [AUX_SW-1:0] side_pick,
    input  logic              main_pick,
    input  logic              slice_en,
    input  logic [DW-1:0]     div_cfg,
    output logic              clk_out,
    output logic [1:0]        src_active
);
    logic aux_clk;
    logic mclk;

    clkslice_aux_sel #(.N(AUX_N)) u_aux (
        .clks    (side_clks),
        .pick    (side_pick),
        .aux_clk (aux_clk)
    );

    clkslice_gf_mux #(.NSRC(2)) u_gf (
        .rst_n   (rst_n),
        .src_clk ({aux_clk, base_clk}),
        .pick    (main_pick),
        .mclk    (mclk),
        .own_q   (src_active)
    );

    clkslice_divgate #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_div (
        .rst_n   (rst_n),
        .mclk    (mclk),
        .en_req  (slice_en),
        .div_cfg (div_cfg),
        .clk_out (clk_out)
    );
endmodule

// File: tb/clkslice_test.sv
`timescale 1ns/1ps
module clkslice_test;
    localparam int AUX_N = 4;
    localparam int INT_W = 8;
    localparam int DW    = INT_W + 8;

    logic             rst_n = 1'b0;
    logic             base_clk = 1'b0;
    logic [AUX_N-1:0] side_clks = '0;
    logic [1:0]       side_pick = '0;
    logic             main_pick = 1'b0;
    logic             slice_en = 1'b1;
    logic [DW-1:0]    div_cfg = 16'h0100;
    logic             clk_out;
    logic [1:0]       src_active;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;
    bit both_seen = 0;
    longint rise_cnt = 0;
    longint last_rise = 0;
    longint min_hi = 1000000;

    // 125 MHz base; side clocks of 10, 14, 6 and 22 ns.
    always #4  base_clk = ~base_clk;
    always #5  side_clks[0] = ~side_clks[0];
    always #7  side_clks[1] = ~side_clks[1];
    always #3  side_clks[2] = ~side_clks[2];
    always #11 side_clks[3] = ~side_clks[3];

    clkslice #(.AUX_N(AUX_N), .INT_W(INT_W)) uut (
        .rst_n(rst_n), .base_clk(base_clk), .side_clks(side_clks),
        .side_pick(side_pick), .main_pick(main_pick), .slice_en(slice_en),
        .div_cfg(div_cfg), .clk_out(clk_out), .src_active(src_active)
    );

    always @(posedge clk_out) begin
        rise_cnt  = rise_cnt + 1;
        last_rise = longint'($time);
    end
    always @(negedge clk_out) begin
        if (longint'($time) - last_rise < min_hi) min_hi = longint'($time) - last_rise;
    end
    always @(src_active) if (src_active == 2'b11) both_seen = 1;

    task automatic chk(input string req, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic meas(output longint per, output longint hi);
        longint t0, t1;
        @(posedge clk_out); t0 = longint'($time);
        @(negedge clk_out); t1 = longint'($time);
        @(posedge clk_out);
        per = longint'($time) - t0;
        hi  = t1 - t0;
    endtask

    task automatic wait_own(input logic [1:0] tgt, output longint took);
        longint t0 = longint'($time);
        for (int k = 0; k < 100; k++) begin
            if (src_active == tgt) break;
            #2;
        end
        took = longint'($time) - t0;
    endtask

    task automatic t_reset;
        #50;
        chk("R1 src_active in reset", src_active, 0);
        chk("R1 clk_out in reset", clk_out, 0);
        #3 rst_n = 1'b1;
        repeat (5) @(posedge base_clk);
        #1;
        chk("R1 base owns after reset", src_active, 2'b01);
    endtask

    task automatic t_pass;
        longint p, h;
        repeat (3) @(posedge clk_out);
        meas(p, h);
        chk("R5 pass period", p, 8);
        chk("R5 pass high", h, 4);
        div_cfg = {8'd1, 8'd200};
        repeat (4) @(posedge clk_out);
        meas(p, h);
        chk("R5 fraction ignored period", p, 8);
    endtask

    task automatic t_intdiv;
        longint p, h;
        div_cfg = {8'd3, 8'd0};
        repeat (4) @(posedge clk_out);
        meas(p, h);
        chk("R6 div3 period", p, 24);
        chk("R6 div3 high", h, 8);
        div_cfg = {8'd4, 8'd0};
        repeat (3) @(posedge clk_out);
        meas(p, h);
        chk("R6 div4 period", p, 32);
        chk("R6 div4 high", h, 16);
        div_cfg = {8'd5, 8'd0};
        repeat (3) @(posedge clk_out);
        meas(p, h);
        chk("R6 div5 period", p, 40);
        chk("R6 div5 high", h, 16);
    endtask

    task automatic t_frac;
        longint t0, p, h, odd;
        div_cfg = {8'd3, 8'd64};
        repeat (4) @(posedge clk_out);
        t0 = longint'($time);
        repeat (256) @(posedge clk_out);
        chk("R7 256 periods of 3+64/256", longint'($time) - t0, (256 * 3 + 64) * 8);
        odd = 0;
        for (int k = 0; k < 8; k++) begin
            meas(p, h);
            if (p != 24 && p != 32) odd++;
        end
        chk("R7 periods are N or N+1", odd, 0);
    endtask

    task automatic t_enable;
        longint c0, p, h;
        div_cfg = {8'd3, 8'd0};
        repeat (3) @(posedge clk_out);
        min_hi = 1000000;
        slice_en = 1'b0;
        #200;
        c0 = rise_cnt;
        #200;
        chk("R8 divided output stopped", rise_cnt, c0);
        chk("R8 stopped low", clk_out, 0);
        chk("R8 no runt while stopping", (min_hi >= 8) ? 1 : 0, 1);
        slice_en = 1'b1;
        meas(p, h);
        chk("R10 first high after restart", h, 8);
        chk("R10 first period after restart", p, 24);
        div_cfg = {8'd1, 8'd0};
        repeat (4) @(posedge clk_out);
        slice_en = 1'b0;
        #100;
        c0 = rise_cnt;
        #200;
        chk("R8 pass output stopped", rise_cnt, c0);
        chk("R8 pass stopped low", clk_out, 0);
        slice_en = 1'b1;
        meas(p, h);
        chk("R10 pass restart high", h, 4);
    endtask

    task automatic t_zero;
        longint c0, p, h;
        div_cfg = {8'd0, 8'd0};
        #200;
        c0 = rise_cnt;
        #200;
        chk("R9 zero integer holds", rise_cnt, c0);
        chk("R9 zero integer low", clk_out, 0);
        div_cfg = {8'd2, 8'd0};
        repeat (2) @(posedge clk_out);
        meas(p, h);
        chk("R9 restart after zero", p, 16);
    endtask

    task automatic t_switch;
        longint took, p, h;
        div_cfg = {8'd1, 8'd0};
        side_pick = 2'd1;
        #40;
        main_pick = 1'b1;
        wait_own(2'b10, took);
        chk("R3 aux owns after switch", src_active, 2'b10);
        chk("R3 switch time bound", (took <= 100) ? 1 : 0, 1);
        repeat (3) @(posedge clk_out);
        meas(p, h);
        chk("R4 side clock 1 period", p, 14);
        main_pick = 1'b0;
        wait_own(2'b01, took);
        chk("R3 base owns again", src_active, 2'b01);
        repeat (3) @(posedge clk_out);
        meas(p, h);
        chk("R3 base period again", p, 8);
        side_pick = 2'd2;
        #40;
        main_pick = 1'b1;
        wait_own(2'b10, took);
        repeat (3) @(posedge clk_out);
        meas(p, h);
        chk("R4 side clock 2 period", p, 6);
        div_cfg = {8'd2, 8'd0};
        repeat (3) @(posedge clk_out);
        meas(p, h);
        chk("R6 div2 on side clock", p, 12);
        chk("R2 never both owners", both_seen, 0);
    endtask

    initial begin
        t_reset;
        t_pass;
        t_intdiv;
        t_frac;
        t_enable;
        t_zero;
        t_switch;
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule